// File: doc/BRIEF.md
# SDRAM Bank Configuration and Address Decode

This block keeps the configuration state of a memory controller that serves up to four SDRAM banks, and turns that state into a live address decoder. Software reaches every register through two bus locations. One location holds a register index. The other reads or writes the register that the index currently selects. The register set covers per-bank base/size/enable words, a controller configuration word and its status mirror, refresh and power-management settings, an error address, write-one-to-clear bus error words, ECC configuration, and an ECC error word that drives an interrupt.

The decoder is purely combinational. It takes a system address and reports which bank, if any, claims it, along with the offset inside that bank. A bank claims an address only while the controller is enabled. The lowest-numbered claiming bank wins. When no bank claims the address, a miss flag is raised.

Top module: `sdram_bank_cfg`

## Requirements
- R1: A bus write to the index location (default 0x010) stores the full 32-bit index. A write to the data location (default 0x011) updates the selected register, and the new value is visible from the next cycle. `bus_rdata` is combinational: it shows the index at the index location, the selected register at the data location, and 0 at any other bus address. Writes to other bus addresses change nothing.
- R2: After reset, the register values are: refresh 0x05F00000, power management 0x07C00000, configuration 0x00800000, and every other readable register 0. The index also resets to 0.
- R3: Register writes are stored with these masks. Refresh keeps the bits of 0x3FF80000. ECC configuration keeps the bits of 0x00F00000. The error address (index 0x10) is stored in full. Power management stores (value & 0xF8000000) | 0x07C00000.
- R4: Writes to the status register (index 0x24) are ignored. Index 0x80 (timing) always reads 0xFFFFFFFF. Any index that names no register also reads 0xFFFFFFFF. This includes a bank index at or above the bank count.
- R5: Configuration writes (index 0x20) are masked with 0xFFE00000. When bit 31 goes 0→1, status bit 31 is cleared. When bit 31 goes 1→0, status bit 31 is set. Status bit 30 follows each transition of configuration bit 30. Status changes only on such transitions.
- R6: Bank words sit at indexes 0x40, 0x44, 0x48 and 0x4C for banks 0–3. They are stored masked with 0xFFDEE001. Bits 31:23 are the base, bits 19:17 the size code, and bit 0 the enable.
- R7: A bank hits when configuration bit 31 is set, its enable bit is set, its size code is 0–6, and the address lies in [base, base + 4 MiB·2^code). On a hit, `dec_offset` is the address minus the base.
- R8: When several banks hit, the lowest-numbered bank is reported.
- R9: When no bank hits, `dec_miss` is 1, `dec_hit` is 0, and `dec_bank` and `dec_offset` are 0. Size code 7, a cleared bank enable, and a cleared configuration bit 31 each force a miss.
- R10: Writing to a bus error word (index 0x00 or 0x08) clears the bits written as 1. Both words read 0 from reset.
- R11: ECC error writes (index 0x98) are stored masked with 0xFFF0F000. `ecc_irq` is 1 exactly while the stored ECC error word is nonzero. It changes in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Bus register address |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ecc_irq | output | 1 | ECC error interrupt |
| dec_addr | input | 32 | System address to decode |
| dec_hit | output | 1 | Some bank claims `dec_addr` |
| dec_bank | output | BANK_W | Index of the claiming bank |
| dec_offset | output | 32 | Offset of `dec_addr` within the claiming bank |
| dec_miss | output | 1 | No bank claims `dec_addr` |

## Verification
Register writes land at the clock edge that follows the strobe. The bench drives every write at a falling edge, so the written value, the status mirror and `ecc_irq` all read back correctly at the next falling edge. Read data and the decoder outputs have zero latency. The bench therefore samples them 1 ns after changing the address, well away from any rising edge. For every bank and every size code, the decode sweep probes the base, the last byte, one past the end and one below the base. The expected result comes from shadow copies of the written words.

// File: rtl/sbc_pkg.sv
// Shared constants for the SDRAM bank configuration block.
// Assumes 32-bit register words and the fixed indirect index map below.
package sbc_pkg;
    typedef logic [31:0] word_t;

    localparam word_t IDX_BERR0  = 32'h00;
    localparam word_t IDX_BERR1  = 32'h08;
    localparam word_t IDX_EADDR  = 32'h10;
    localparam word_t IDX_CFG    = 32'h20;
    localparam word_t IDX_STAT   = 32'h24;
    localparam word_t IDX_RFSH   = 32'h30;
    localparam word_t IDX_PWR    = 32'h34;
    localparam word_t IDX_BANK0  = 32'h40;
    localparam word_t IDX_TIMING = 32'h80;
    localparam word_t IDX_ECFG   = 32'h94;
    localparam word_t IDX_ESTAT  = 32'h98;

    localparam word_t MSK_CFG    = 32'hFFE0_0000;
    localparam word_t MSK_RFSH   = 32'h3FF8_0000;
    localparam word_t MSK_PWR    = 32'hF800_0000;
    localparam word_t FIX_PWR    = 32'h07C0_0000;
    localparam word_t MSK_ECFG   = 32'h00F0_0000;
    localparam word_t MSK_ESTAT  = 32'hFFF0_F000;
    localparam word_t MSK_BANK   = 32'hFFDE_E001;

    localparam word_t RST_RFSH   = 32'h05F0_0000;
    localparam word_t RST_PWR    = 32'h07C0_0000;
    localparam word_t RST_CFG    = 32'h0080_0000;

    localparam word_t ALL_ONES   = 32'hFFFF_FFFF;
    localparam logic [32:0] UNIT_SIZE = 33'h0_0040_0000;
    localparam logic [2:0]  SIZE_BAD  = 3'd7;
endpackage

// File: rtl/sbc_regs.sv
// Indirect register file: index latch, data-port writes with field masks,
// enable-transition status mirror and the ECC interrupt flop.
// Assumes one bus access per cycle; reads are side-effect free.
module sbc_regs
    import sbc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] PORT_IDX  = 10'h010,
    parameter logic [ADDR_W-1:0] PORT_DATA = 10'h011
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  word_t                       bus_wdata,
    output word_t                       bus_rdata,
    output logic                        ecc_irq,
    output logic                        ctl_en,
    output logic [NUM_BANKS-1:0][31:0]  bank_words
);
    word_t idx_q, berr0_q, berr1_q, eaddr_q, cfg_q, stat_q;
    word_t rfsh_q, pwr_q, ecfg_q, estat_q, reg_rd;
    logic  irq_q;

    logic wr_idx, wr_dat;
    assign wr_idx = bus_we && (bus_addr == PORT_IDX);
    assign wr_dat = bus_we && (bus_addr == PORT_DATA);

    word_t cfg_new, estat_new;
    assign cfg_new   = bus_wdata & MSK_CFG;
    assign estat_new = bus_wdata & MSK_ESTAT;

    // Index latch and all non-bank registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            berr0_q <= '0;
            berr1_q <= '0;
            eaddr_q <= '0;
            cfg_q   <= RST_CFG;
            stat_q  <= '0;
            rfsh_q  <= RST_RFSH;
            pwr_q   <= RST_PWR;
            ecfg_q  <= '0;
            estat_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (wr_idx) idx_q <= bus_wdata;
            if (wr_dat) begin
                case (idx_q)
                    IDX_BERR0: berr0_q <= berr0_q & ~bus_wdata;
                    IDX_BERR1: berr1_q <= berr1_q & ~bus_wdata;
                    IDX_EADDR: eaddr_q <= bus_wdata;
                    IDX_CFG: begin
                        cfg_q <= cfg_new;
                        if (!cfg_q[31] && cfg_new[31])      stat_q[31] <= 1'b0;
                        else if (cfg_q[31] && !cfg_new[31]) stat_q[31] <= 1'b1;
                        if (!cfg_q[30] && cfg_new[30])      stat_q[30] <= 1'b1;
                        else if (cfg_q[30] && !cfg_new[30]) stat_q[30] <= 1'b0;
                    end
                    IDX_RFSH:  rfsh_q <= bus_wdata & MSK_RFSH;
                    IDX_PWR:   pwr_q  <= (bus_wdata & MSK_PWR) | FIX_PWR;
                    IDX_ECFG:  ecfg_q <= bus_wdata & MSK_ECFG;
                    IDX_ESTAT: begin
                        estat_q <= estat_new;
                        irq_q   <= (estat_new != '0);
                    end
                    default: ;
                endcase
            end
        end
    end

    // One masked configuration word per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam word_t MY_IDX = IDX_BANK0 + word_t'(4 * b);
        word_t bw_q;
        // Store this bank's word on a data-port write to its index.
        always_ff @(posedge clk) begin
            if (!rst_n)                        bw_q <= '0;
            else if (wr_dat && idx_q == MY_IDX) bw_q <= bus_wdata & MSK_BANK;
        end
        assign bank_words[b] = bw_q;
    end

    // Select the register named by the index; unknown names read all ones.
    always_comb begin
        reg_rd = ALL_ONES;
        case (idx_q)
            IDX_BERR0: reg_rd = berr0_q;
            IDX_BERR1: reg_rd = berr1_q;
            IDX_EADDR: reg_rd = eaddr_q;
            IDX_CFG:   reg_rd = cfg_q;
            IDX_STAT:  reg_rd = stat_q;
            IDX_RFSH:  reg_rd = rfsh_q;
            IDX_PWR:   reg_rd = pwr_q;
            IDX_ECFG:  reg_rd = ecfg_q;
            IDX_ESTAT: reg_rd = estat_q;
            default:   reg_rd = ALL_ONES;
        endcase
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (idx_q == IDX_BANK0 + word_t'(4 * b)) reg_rd = bank_words[b];
        end
    end

    // Route the bus read to the index, the selected register or zero.
    always_comb begin
        if (bus_addr == PORT_IDX)       bus_rdata = idx_q;
        else if (bus_addr == PORT_DATA) bus_rdata = reg_rd;
        else                            bus_rdata = '0;
    end

    assign ecc_irq = irq_q;
    assign ctl_en  = cfg_q[31];
endmodule

// File: rtl/sbc_bank_match.sv
// Range check of one address against one bank word.
// Assumes base in bits 31:23, size code in 19:17, enable in bit 0.
module sbc_bank_match
    import sbc_pkg::*;
(
    input  logic  ctl_en,
    input  word_t bank_word,
    input  word_t addr,
    output logic  hit,
    output word_t offset
);
    word_t       base;
    logic [2:0]  code;
    logic [32:0] span, diff;
    logic        unused_bits;

    assign base        = {bank_word[31:23], 23'b0};
    assign code        = bank_word[19:17];
    assign span        = UNIT_SIZE << code;
    assign diff        = {1'b0, addr} - {1'b0, base};
    assign unused_bits = ^{bank_word[22:20], bank_word[16:1]};

    // Hit needs global and bank enable, a legal code and an in-range address.
    always_comb begin
        hit    = ctl_en && bank_word[0] && (code != SIZE_BAD)
                 && !diff[32] && (diff < span);
        offset = diff[31:0];
    end
endmodule

// File: rtl/sbc_prio.sv
// Fixed-priority merge of per-bank hits: lowest bank index wins.
// Assumes each offset is only meaningful while its hit is set.
module sbc_prio
    import sbc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic [NUM_BANKS-1:0]       hits,
    input  logic [NUM_BANKS-1:0][31:0] offsets,
    output logic                       any_hit,
    output logic [BANK_W-1:0]          bank,
    output word_t                      offset,
    output logic                       miss
);
    // Scan from the top so the lowest hitting bank is written last.
    always_comb begin
        any_hit = 1'b0;
        bank    = '0;
        offset  = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (hits[b]) begin
                any_hit = 1'b1;
                bank    = BANK_W'(b);
                offset  = offsets[b];
            end
        end
        miss = ~|hits;
    end
endmodule

// File: rtl/sdram_bank_cfg.sv
// Top: SDRAM bank configuration registers plus live bank address decode.
// Assumes NUM_BANKS between 1 and 4 (bank indexes 0x40..0x4C).
module sdram_bank_cfg
    import sbc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] PORT_IDX  = 10'h010,
    parameter logic [ADDR_W-1:0] PORT_DATA = 10'h011,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ecc_irq,
    input  logic [31:0]       dec_addr,
    output logic              dec_hit,
    output logic [BANK_W-1:0] dec_bank,
    output logic [31:0]       dec_offset,
    output logic              dec_miss
);
    logic                       ctl_en;
    logic [NUM_BANKS-1:0][31:0] bank_words;
    logic [NUM_BANKS-1:0]       hits;
    logic [NUM_BANKS-1:0][31:0] offsets;

    sbc_regs #(
        .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
        .PORT_IDX(PORT_IDX), .PORT_DATA(PORT_DATA)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ecc_irq(ecc_irq),
        .ctl_en(ctl_en), .bank_words(bank_words)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
        sbc_bank_match u_match (
            .ctl_en(ctl_en), .bank_word(bank_words[b]), .addr(dec_addr),
            .hit(hits[b]), .offset(offsets[b])
        );
    end

    sbc_prio #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_prio (
        .hits(hits), .offsets(offsets), .any_hit(dec_hit),
        .bank(dec_bank), .offset(dec_offset), .miss(dec_miss)
    );
endmodule

// File: rtl/sbc_checker.sv
// Property checker for sdram_bank_cfg, attached with bind below.
module sbc_checker #(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] PORT_DATA = 10'h011,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              ecc_irq,
    input logic              ctl_on,
    input logic [31:0]       dec_addr,
    input logic              dec_hit,
    input logic [BANK_W-1:0] dec_bank,
    input logic [31:0]       dec_offset,
    input logic              dec_miss
);
    AST_IRQ_RISE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ecc_irq) |-> $past(bus_we && bus_addr == PORT_DATA)); // R11
    AST_IRQ_FALL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ecc_irq) |-> $past(bus_we && bus_addr == PORT_DATA)); // R11
    AST_CTL_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> $stable(ctl_on)); // R5
    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_on |-> !dec_hit); // R9
    AST_OFFSET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> (dec_offset < 32'h1000_0000) && (dec_offset <= dec_addr)); // R7
    AST_MISS_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dec_miss |-> (dec_offset == 32'h0) && (dec_bank == '0) && !dec_hit); // R9
endmodule

bind sdram_bank_cfg sbc_checker #(
    .ADDR_W(ADDR_W), .PORT_DATA(PORT_DATA), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .ecc_irq(ecc_irq), .ctl_on(ctl_en), .dec_addr(dec_addr),
    .dec_hit(dec_hit), .dec_bank(dec_bank), .dec_offset(dec_offset),
    .dec_miss(dec_miss)
);

// File: tb/sim_sdram_bank_cfg.sv
`timescale 1ns/1ps
module sim_sdram_bank_cfg;
    localparam logic [9:0] P_IDX = 10'h010;
    localparam logic [9:0] P_DAT = 10'h011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ecc_irq;
    logic [31:0] dec_addr = '0;
    logic        dec_hit, dec_miss;
    logic [1:0]  dec_bank;
    logic [31:0] dec_offset;

    int checks = 0;
    int fails  = 0;
    logic [31:0] shadow [4];
    logic        ctl = 1'b0;

    always #2.5 clk = ~clk;

    sdram_bank_cfg u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ecc_irq(ecc_irq),
        .dec_addr(dec_addr), .dec_hit(dec_hit), .dec_bank(dec_bank),
        .dec_offset(dec_offset), .dec_miss(dec_miss)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_reg(input logic [31:0] idx, input logic [31:0] d);
        bus_wr(P_IDX, idx);
        bus_wr(P_DAT, d);
        if (idx >= 32'h40 && idx <= 32'h4C && idx[1:0] == 2'b00)
            shadow[(idx - 32'h40) >> 2] = d & 32'hFFDE_E001;
        if (idx == 32'h20) ctl = d[31];
    endtask

    task automatic rd_reg(input logic [31:0] idx, output logic [31:0] v);
        bus_wr(P_IDX, idx);
        bus_addr = P_DAT;
        #1 v = bus_rdata;
    endtask

    task automatic reg_chk(input string req, input logic [31:0] idx, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(idx, v);
        chk(req, {32'b0, v}, {32'b0, exp});
    endtask

    function automatic logic [63:0] exp_dec(input logic [31:0] a);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w    = shadow[i];
            logic [2:0]  code = w[19:17];
            logic [63:0] base = {32'b0, w & 32'hFF80_0000};
            logic [63:0] sz   = 64'h40_0000 << code;
            if (ctl && w[0] && code != 3'd7 && {32'b0, a} >= base && {32'b0, a} < base + sz)
                return {28'b0, 1'b1, 1'b0, 2'(i), a - base[31:0]};
        end
        return {28'b0, 1'b0, 1'b1, 2'b0, 32'b0};
    endfunction

    task automatic dec_chk(input string req, input logic [31:0] a);
        dec_addr = a;
        #1 chk(req, {28'b0, dec_hit, dec_miss, dec_bank, dec_offset}, exp_dec(a));
    endtask

    initial begin
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset values, decode off at reset.
        reg_chk("R2 rfsh", 32'h30, 32'h05F0_0000);
        reg_chk("R2 pwr",  32'h34, 32'h07C0_0000);
        reg_chk("R2 cfg",  32'h20, 32'h0080_0000);
        reg_chk("R2 stat", 32'h24, 32'h0);
        reg_chk("R2 estat", 32'h98, 32'h0);
        reg_chk("R2 bank0", 32'h40, 32'h0);
        chk("R2 irq", {63'b0, ecc_irq}, 64'h0);
        dec_chk("R9 reset miss", 32'h0000_0100);

        // R1: index port readback and unrelated bus addresses.
        bus_wr(P_IDX, 32'h1234_5678);
        bus_addr = P_IDX; #1 chk("R1 idx read", {32'b0, bus_rdata}, 64'h1234_5678);
        wr_reg(32'h10, 32'hA5A5_0F0F);
        bus_wr(10'h012, 32'hFFFF_FFFF);
        bus_addr = 10'h012; #1 chk("R1 other addr", {32'b0, bus_rdata}, 64'h0);
        reg_chk("R1 eaddr kept", 32'h10, 32'hA5A5_0F0F);

        // R3: field masks.
        wr_reg(32'h30, 32'hFFFF_FFFF); reg_chk("R3 rfsh", 32'h30, 32'h3FF8_0000);
        wr_reg(32'h34, 32'h0000_0000); reg_chk("R3 pwr", 32'h34, 32'h07C0_0000);
        wr_reg(32'h34, 32'hFFFF_FFFF); reg_chk("R3 pwr ones", 32'h34, 32'hFFC0_0000);
        wr_reg(32'h94, 32'hFFFF_FFFF); reg_chk("R3 ecfg", 32'h94, 32'h00F0_0000);

        // R4: read-only status, all-ones reads.
        wr_reg(32'h24, 32'hFFFF_FFFF); reg_chk("R4 stat ro", 32'h24, 32'h0);
        wr_reg(32'h80, 32'h0);         reg_chk("R4 timing", 32'h80, 32'hFFFF_FFFF);
        reg_chk("R4 unknown", 32'h04, 32'hFFFF_FFFF);
        reg_chk("R4 bank4", 32'h50, 32'hFFFF_FFFF);

        // R10: write-one-to-clear error words.
        wr_reg(32'h00, 32'hFFFF_FFFF); reg_chk("R10 berr0", 32'h00, 32'h0);
        wr_reg(32'h08, 32'hFFFF_FFFF); reg_chk("R10 berr1", 32'h08, 32'h0);

        // R5: config mask and status mirror.
        wr_reg(32'h20, 32'hFFFF_FFFF);
        reg_chk("R5 cfg mask", 32'h20, 32'hFFE0_0000);
        reg_chk("R5 stat on", 32'h24, 32'h4000_0000);
        wr_reg(32'h20, 32'h0);
        reg_chk("R5 stat off", 32'h24, 32'h8000_0000);
        wr_reg(32'h20, 32'h0010_0000);
        reg_chk("R5 stat hold", 32'h24, 32'h8000_0000);
        wr_reg(32'h20, 32'h8000_0000);
        reg_chk("R5 stat reen", 32'h24, 32'h0);

        // R11: ECC error word and interrupt.
        wr_reg(32'h98, 32'hFFFF_FFFF);
        chk("R11 irq up", {63'b0, ecc_irq}, 64'h1);
        reg_chk("R11 estat mask", 32'h98, 32'hFFF0_F000);
        wr_reg(32'h98, 32'h0000_1000);
        chk("R11 irq held", {63'b0, ecc_irq}, 64'h1);
        wr_reg(32'h98, 32'h0);
        chk("R11 irq down", {63'b0, ecc_irq}, 64'h0);
        wr_reg(32'h98, 32'h000F_0FFF);
        chk("R11 masked only", {63'b0, ecc_irq}, 64'h0);

        // R6: bank word mask.
        wr_reg(32'h40, 32'hFFFF_FFFF); reg_chk("R6 bank0 mask", 32'h40, 32'hFFDE_E001);
        wr_reg(32'h40, 32'h0);

        // R7/R9: sweep every bank and size code.
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 8; c++) begin
                logic [31:0] base = 32'(b) << 29;
                logic [31:0] sz   = 32'h40_0000 << c;
                wr_reg(32'h40 + 32'(4 * b), base | (32'(c) << 17) | 32'h1);
                dec_chk("R7 base", base);
                dec_chk("R7 last", base + sz - 1);
                dec_chk("R9 end", base + sz);
                dec_chk("R9 below", base - 1);
            end
            wr_reg(32'h40 + 32'(4 * b), 32'h0);
        end

        // R8: overlapping banks, lowest wins.
        wr_reg(32'h44, 32'h2000_0001);
        wr_reg(32'h48, 32'h2000_0001);
        dec_chk("R8 bank1 over 2", 32'h2000_0010);
        wr_reg(32'h40, 32'h000C_0001);
        wr_reg(32'h4C, 32'h000C_0001);
        dec_chk("R8 bank0 over 3", 32'h0000_0100);
        wr_reg(32'h40, 32'h000C_0000);
        dec_chk("R9 bank0 disabled", 32'h0000_0100);
        wr_reg(32'h20, 32'h0);
        dec_chk("R9 ctl off", 32'h0000_0100);
        dec_chk("R9 ctl off b1", 32'h2000_0010);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule